// File: doc/BRIEF.md
# Four-Mode Serial Shift Engine

This block moves one 8-bit character at a time over a serial line. It can run in four framings. The first is a clocked shift where the block drives the clock. The second is a half-duplex asynchronous link with one start bit, eight data bits and one stop bit. The third is a clocked bus framing in which the block sends a low start bit ahead of the data. The fourth is a bus framing driven by a remote clock: the block detects a start condition, takes in eight bits, and finishes when it sees a stop condition. Data goes out and comes in least significant bit first in every framing.

A single divider input sets the timing. In the two framings where the block drives the clock, the clock period is `2*(div+1)` cycles, which gives 2 to 512 cycles for an 8-bit divider. In the asynchronous framing, the bit period is `8*(div+1)` cycles, which gives 8 to 2048 cycles. Pad drivers are outside the block. The block shows each output as a value plus an enable.

The framing is chosen with `mode_i`. Its encoding is 0 for clocked shift, 1 for asynchronous, 2 for clocked bus with start bit, and 3 for remote-clocked bus. A one-cycle `start_i` pulse launches a transmit. For one cycle, `done_o` marks the moment the transfer is complete and `rx_data_o` holds the new byte.

Top module: `sport4_engine`

## Requirements
- R1: After reset, `sck_o`=1, `sck_oe_o`=0, `sdo_o`=1, `sdo_oe_o`=0, `done_o`=0, `rx_data_o`=0 and `frame_err_o`=0. Whenever `sdo_oe_o` is 0, `sdo_o` is 1.
- R2: In mode 0, a `start_i` accepted at clock edge E makes `sdo_o` present `tx_data_i` bit 0 first. `sdo_o` moves to the next bit only while `sck_o` is low, just after a falling edge. Each `sck_o` period lasts `2*(div_i+1)` cycles. `done_o` goes high after edge E+16*(div_i+1).
- R3: In the two framings where the block drives the clock, `sdi_i` is sampled when `sck_o` rises, and the first sample is the least significant bit. `rx_data_o` changes only in a cycle where `done_o` is high.
- R4: In mode 2, a 0 start bit goes out ahead of the eight data bits, so there are nine clock periods. `done_o` goes high after edge E+18*(div_i+1). `rx_data_o` holds the last eight samples.
- R5: In mode 1, transmit sends, one after another: a 0 start bit, the 8 data bits with bit 0 first, and a 1 stop bit. Each bit lasts `8*(div_i+1)` cycles. `done_o` goes high after edge E+80*(div_i+1).
- R6: In mode 1 while idle, a falling edge on `sdi_i` starts a receive, and every bit is sampled at its middle. If `sdi_i` is high again at the middle of the start bit, the receive is dropped, with no `done_o` and no change to `rx_data_o`.
- R7: An asynchronous receive whose stop bit samples low sets `frame_err_o` to 1. A receive with a good stop bit clears it. `frame_err_o` changes only together with `done_o`.
- R8: In mode 3, a fall of `sdi_i` while `sck_i` is high marks a start. Eight bits are sampled on rising edges of `sck_i`, bit 0 first. A rise of `sdi_i` while `sck_i` is high after the eighth bit raises `done_o`.
- R9: `start_i` has no effect while a transfer is running or when mode 3 is selected.
- R10: `done_o` is high for exactly one cycle per finished transfer.
- R11: `sck_oe_o` is high only during a transfer in mode 0 or mode 2. Whenever `sck_oe_o` is low, `sck_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Framing select: 0 clocked shift, 1 asynchronous, 2 clocked bus with start bit, 3 remote-clocked bus |
| div_i | input | DIV_W | Timing divider; half clock period is div+1, asynchronous half bit is 4*(div+1) |
| tx_data_i | input | DATA_W | Byte to transmit |
| start_i | input | 1 | One-cycle launch strobe |
| sck_i | input | 1 | Remote serial clock (mode 3) |
| sdi_i | input | 1 | Serial data in |
| sck_o | output | 1 | Serial clock value |
| sck_oe_o | output | 1 | Serial clock drive enable |
| sdo_o | output | 1 | Serial data value |
| sdo_oe_o | output | 1 | Serial data drive enable |
| rx_data_o | output | DATA_W | Last received byte |
| done_o | output | 1 | One-cycle transfer-complete pulse |
| frame_err_o | output | 1 | Stop bit of the last asynchronous receive was low |

## Verification
Completion latency is fixed by the divider. If a start is accepted at edge E, the clocked modes finish 16 or 18 times (div+1) cycles later, and asynchronous transmit finishes 80 times (div+1) cycles later. An asynchronous receive finishes 19 half-bits after the edge that sees the falling start edge. The bench counts falling clock edges from the launch edge and requires `done_o` on exactly the predicted count, then checks that it is low on the next one. Serial bits are captured at the middle of each asynchronous bit, and at the edge before each `sck_o` rise in the clocked modes. For mode 3, the bench changes its inputs on falling edges of the clock, and the stop condition must raise `done_o` within the hold time that follows.

// File: rtl/sport4_pkg.sv
package sport4_pkg;

    typedef enum logic [1:0] {
        M_SYNC    = 2'd0,
        M_ASYNC   = 2'd1,
        M_BUS_CLK = 2'd2,
        M_BUS_DET = 2'd3
    } mode_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_MTX,
        S_ATX,
        S_ARX,
        S_SLV
    } st_e;

endpackage

// File: rtl/sport4_tick.sv
module sport4_tick #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             tick
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign tick = run && (cnt_q == limit);

    always_comb begin
        if (!run || tick) cnt_d = '0;
        else              cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/sport4_edges.sv
module sport4_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic sdi_i,
    output logic sck_rise,
    output logic sck_hi,
    output logic sdi_fall,
    output logic sdi_rise
);
    logic sck_q, sdi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q <= 1'b1;
            sdi_q <= 1'b1;
        end else begin
            sck_q <= sck_i;
            sdi_q <= sdi_i;
        end
    end

    assign sck_rise = ~sck_q & sck_i;
    assign sck_hi   = sck_q & sck_i;
    assign sdi_fall = sdi_q & ~sdi_i;
    assign sdi_rise = ~sdi_q & sdi_i;
endmodule

// File: rtl/sport4_engine.sv
module sport4_engine
    import sport4_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic [DIV_W-1:0]  div_i,
    input  logic [DATA_W-1:0] tx_data_i,
    input  logic              start_i,
    input  logic              sck_i,
    input  logic              sdi_i,
    output logic              sck_o,
    output logic              sck_oe_o,
    output logic              sdo_o,
    output logic              sdo_oe_o,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              done_o,
    output logic              frame_err_o
);
    localparam int FRM_W = DATA_W + 2;
    localparam int K_W   = $clog2(2 * FRM_W + 1);
    localparam int N_W   = $clog2(DATA_W + 1);
    localparam int CNT_W = DIV_W + 2;

    localparam logic [K_W-1:0] K_ONE       = K_W'(1);
    localparam logic [K_W-1:0] K_SYNC_END  = K_W'(2 * DATA_W);
    localparam logic [K_W-1:0] K_BUS_END   = K_W'(2 * (DATA_W + 1));
    localparam logic [K_W-1:0] K_ATX_END   = K_W'(2 * FRM_W);
    localparam logic [K_W-1:0] K_ARX_STOP  = K_W'(2 * FRM_W - 1);
    localparam logic [N_W-1:0] N_FULL      = N_W'(DATA_W);

    typedef struct packed {
        st_e               st;
        mode_e             mode;
        logic [K_W-1:0]    k;
        logic [FRM_W-1:0]  txsh;
        logic [DATA_W-1:0] rxsh;
        logic [N_W-1:0]    nb;
        logic              sck;
        logic              sck_oe;
        logic              sdo;
        logic              sdo_oe;
        logic              done;
        logic [DATA_W-1:0] rx;
        logic              ferr;
    } regs_t;

    localparam regs_t RST = '{
        st: S_IDLE, mode: M_SYNC, k: '0, txsh: '1, rxsh: '0, nb: '0,
        sck: 1'b1, sck_oe: 1'b0, sdo: 1'b1, sdo_oe: 1'b0, done: 1'b0,
        rx: '0, ferr: 1'b0
    };

    regs_t r_d, r_q;

    logic             tick, run;
    logic [CNT_W-1:0] limit;
    logic             sck_rise, sck_hi, sdi_fall, sdi_rise;
    logic             start_cond, stop_cond;
    logic [K_W-1:0]   k_nx, mtx_end;
    logic [FRM_W-1:0] tx_nx, load_sync, load_frm;
    logic [DATA_W-1:0] rx_nx;
    mode_e            mode_in;

    assign mode_in = mode_e'(mode_i);
    assign run     = (r_q.st == S_MTX) || (r_q.st == S_ATX) || (r_q.st == S_ARX);
    assign limit   = (r_q.mode == M_ASYNC) ? {div_i, 2'b11} : {2'b00, div_i};

    sport4_tick #(.CNT_W(CNT_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .limit (limit),
        .tick  (tick)
    );

    sport4_edges u_edges (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_i    (sck_i),
        .sdi_i    (sdi_i),
        .sck_rise (sck_rise),
        .sck_hi   (sck_hi),
        .sdi_fall (sdi_fall),
        .sdi_rise (sdi_rise)
    );

    assign start_cond = sck_hi & sdi_fall;
    assign stop_cond  = sck_hi & sdi_rise;

    assign k_nx      = r_q.k + 1'b1;
    assign tx_nx     = {1'b1, r_q.txsh[FRM_W-1:1]};
    assign rx_nx     = {sdi_i, r_q.rxsh[DATA_W-1:1]};
    assign mtx_end   = (r_q.mode == M_SYNC) ? K_SYNC_END : K_BUS_END;
    assign load_sync = {2'b11, tx_data_i};
    assign load_frm  = {1'b1, tx_data_i, 1'b0};

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            S_IDLE: begin
                r_d.k = '0;
                if (mode_in == M_ASYNC && sdi_fall) begin
                    r_d.st   = S_ARX;
                    r_d.mode = M_ASYNC;
                end else if (start_i && mode_in != M_BUS_DET) begin
                    r_d.mode   = mode_in;
                    r_d.sdo_oe = 1'b1;
                    if (mode_in == M_ASYNC) begin
                        r_d.st   = S_ATX;
                        r_d.txsh = load_frm;
                        r_d.sdo  = 1'b0;
                    end else begin
                        r_d.st     = S_MTX;
                        r_d.sck_oe = 1'b1;
                        r_d.txsh   = (mode_in == M_SYNC) ? load_sync : load_frm;
                        r_d.sdo    = (mode_in == M_SYNC) ? tx_data_i[0] : 1'b0;
                    end
                end else if (mode_in == M_BUS_DET && start_cond) begin
                    r_d.st   = S_SLV;
                    r_d.mode = M_BUS_DET;
                    r_d.nb   = '0;
                end
            end
            S_MTX: begin
                if (tick) begin
                    r_d.k = k_nx;
                    if (k_nx[0]) begin
                        r_d.sck = 1'b0;
                        if (k_nx != K_ONE) begin
                            r_d.txsh = tx_nx;
                            r_d.sdo  = tx_nx[0];
                        end
                    end else begin
                        r_d.sck  = 1'b1;
                        r_d.rxsh = rx_nx;
                        if (k_nx == mtx_end) begin
                            r_d.st     = S_IDLE;
                            r_d.done   = 1'b1;
                            r_d.rx     = rx_nx;
                            r_d.sck_oe = 1'b0;
                            r_d.sdo_oe = 1'b0;
                            r_d.sdo    = 1'b1;
                        end
                    end
                end
            end
            S_ATX: begin
                if (tick) begin
                    r_d.k = k_nx;
                    if (k_nx == K_ATX_END) begin
                        r_d.st     = S_IDLE;
                        r_d.done   = 1'b1;
                        r_d.sdo_oe = 1'b0;
                        r_d.sdo    = 1'b1;
                    end else if (!k_nx[0]) begin
                        r_d.txsh = tx_nx;
                        r_d.sdo  = tx_nx[0];
                    end
                end
            end
            S_ARX: begin
                if (tick) begin
                    r_d.k = k_nx;
                    if (k_nx == K_ONE) begin
                        if (sdi_i) r_d.st = S_IDLE;
                    end else if (k_nx == K_ARX_STOP) begin
                        r_d.st   = S_IDLE;
                        r_d.done = 1'b1;
                        r_d.rx   = r_q.rxsh;
                        r_d.ferr = ~sdi_i;
                    end else if (k_nx[0]) begin
                        r_d.rxsh = rx_nx;
                    end
                end
            end
            S_SLV: begin
                if (start_cond) begin
                    r_d.nb = '0;
                end else if (stop_cond) begin
                    r_d.st = S_IDLE;
                    if (r_q.nb == N_FULL) begin
                        r_d.done = 1'b1;
                        r_d.rx   = r_q.rxsh;
                    end
                end else if (sck_rise && r_q.nb != N_FULL) begin
                    r_d.rxsh = rx_nx;
                    r_d.nb   = r_q.nb + 1'b1;
                end
            end
            default: r_d = RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RST;
        else        r_q <= r_d;
    end

    assign sck_o       = r_q.sck;
    assign sck_oe_o    = r_q.sck_oe;
    assign sdo_o       = r_q.sdo;
    assign sdo_oe_o    = r_q.sdo_oe;
    assign rx_data_o   = r_q.rx;
    assign done_o      = r_q.done;
    assign frame_err_o = r_q.ferr;
endmodule

// File: rtl/sport4_engine_chk.sv
module sport4_engine_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode_i,
    input logic              start_i,
    input logic              sck_o,
    input logic              sck_oe_o,
    input logic              sdo_o,
    input logic              sdo_oe_o,
    input logic [DATA_W-1:0] rx_data_o,
    input logic              done_o,
    input logic              frame_err_o
);
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_sdo_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_oe_o |-> sdo_o);

    p_sck_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !sck_oe_o |-> sck_o);

    p_sck_owner_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck_oe_o) |-> ($past(start_i) &&
                             ($past(mode_i) == 2'd0 || $past(mode_i) == 2'd2)));

    p_rx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(rx_data_o));

    p_ferr_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_err_o != $past(frame_err_o)) |-> done_o);

    p_sdo_after_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_oe_o && $past(sck_oe_o) && (sdo_o != $past(sdo_o))) |-> !sck_o);
endmodule

bind sport4_engine sport4_engine_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode_i),
    .start_i     (start_i),
    .sck_o       (sck_o),
    .sck_oe_o    (sck_oe_o),
    .sdo_o       (sdo_o),
    .sdo_oe_o    (sdo_oe_o),
    .rx_data_o   (rx_data_o),
    .done_o      (done_o),
    .frame_err_o (frame_err_o)
);

// File: tb/sport4_engine_tb.sv
module sport4_engine_tb;
    localparam int CLK_PER = 10;
    localparam int WD_LIM  = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'd0;
    logic [7:0] div = 8'd0;
    logic [7:0] tx_data = 8'd0;
    logic       start = 1'b0;
    logic       sck_in = 1'b1;
    logic       sdi_t = 1'b1;
    logic       sdi_m = 1'b1;
    logic       use_mon = 1'b0;
    logic       sdi;
    logic       sck_o, sck_oe_o, sdo_o, sdo_oe_o, done_o, frame_err_o;
    logic [7:0] rx_data_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    assign sdi = use_mon ? sdi_m : sdi_t;

    always #(CLK_PER/2) clk = ~clk;

    sport4_engine u_dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .div_i(div),
        .tx_data_i(tx_data), .start_i(start), .sck_i(sck_in), .sdi_i(sdi),
        .sck_o(sck_o), .sck_oe_o(sck_oe_o), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o),
        .rx_data_o(rx_data_o), .done_o(done_o), .frame_err_o(frame_err_o)
    );

    // remote device model for the clocked modes
    logic [9:0] sframe = '0;
    logic [9:0] cap = '0;
    logic       sck_prev = 1'b1;
    logic       sdo_prev = 1'b1;
    int         fidx = 0;
    int         ridx = 0;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (sck_prev && !sck_o) begin
            sdi_m <= sframe[fidx % 10];
            fidx  <= fidx + 1;
        end
        if (!sck_prev && sck_o) begin
            cap[ridx % 10] <= sdo_prev;
            ridx <= ridx + 1;
        end else if (!sck_oe_o) begin
            fidx <= 0;
            ridx <= 0;
        end
        sck_prev <= sck_o;
        sdo_prev <= sdo_o;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        while (cyc < WD_LIM) @(negedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, WD_LIM);
        finish_run();
    end

    // clocked master transfer (mode 0 or 2); entered at a falling clock edge
    task automatic run_master(input logic [1:0] md, input int dv, input logic [7:0] tx,
                              input logic [7:0] rp, input bit poke);
        int h = dv + 1;
        int nb = (md == 2'd0) ? 8 : 9;
        int j = 0;
        string tg = (md == 2'd0) ? "R2" : "R4";
        sframe  = (md == 2'd0) ? {2'b00, rp} : {1'b0, rp, 1'b0};
        use_mon = 1'b1;
        mode = md; div = 8'(dv); tx_data = tx; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(sck_oe_o && sdo_oe_o, "R11 clock driven during transfer", sck_oe_o, 1);
        while (!done_o && j < 2 * nb * h + 8) begin
            @(negedge clk);
            j++;
            start = (poke && j == 3);
            if (poke && j == 3) tx_data = ~tx;
        end
        start = 1'b0;
        chk(j == 2 * nb * h, {tg, " done latency"}, j, 2 * nb * h);
        chk(rx_data_o == rp, "R3 received byte", rx_data_o, rp);
        @(negedge clk);
        chk(!done_o, "R10 done single cycle", done_o, 0);
        chk(!sck_oe_o && sck_o && sdo_o, "R11 clock released", sck_oe_o, 0);
        if (md == 2'd0) chk(cap[7:0] == tx, poke ? "R9 busy start ignored" : "R2 sent bits",
                            cap[7:0], tx);
        else            chk(cap[8:0] == {tx, 1'b0}, "R4 start bit and data",
                            cap[8:0], {tx, 1'b0});
        use_mon = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_async_tx(input int dv, input logic [7:0] tx);
        int h = 4 * (dv + 1);
        int j = 0;
        logic [9:0] got = '0;
        mode = 2'd1; div = 8'(dv); tx_data = tx; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done_o && j < 20 * h + 8) begin
            @(negedge clk);
            j++;
            if (j % (2 * h) == h && j / (2 * h) < 10) got[j / (2 * h)] = sdo_o;
        end
        chk(j == 20 * h, "R5 done latency", j, 20 * h);
        chk(got == {1'b1, tx, 1'b0}, "R5 line frame", got, {1'b1, tx, 1'b0});
        @(negedge clk);
        chk(!done_o && !sdo_oe_o, "R10 done single cycle", done_o, 0);
    endtask

    // drives one asynchronous frame; returns the falling-edge index where done was seen
    task automatic drive_async(input int dv, input logic [7:0] b, input logic stopb,
                               output int seen_at, output int seen_cnt);
        int h = 4 * (dv + 1);
        int n = 0;
        logic [9:0] fr = {stopb, b, 1'b0};
        seen_at = -1; seen_cnt = 0;
        mode = 2'd1; div = 8'(dv);
        for (int bi = 0; bi < 10; bi++) begin
            sdi_t = fr[bi];
            for (int c = 0; c < 2 * h; c++) begin
                @(negedge clk);
                n++;
                if (done_o) begin
                    seen_cnt++;
                    if (seen_at < 0) seen_at = n;
                end
            end
        end
        sdi_t = 1'b1;
        repeat (2 * h) @(negedge clk);
    endtask

    task automatic ph(input logic s, input logic d, inout int dcnt);
        sck_in = s; sdi_t = d;
        repeat (2) begin
            @(negedge clk);
            if (done_o) dcnt++;
        end
    endtask

    task automatic run_bus_slave(input logic [7:0] b, input bit restart);
        int dcnt = 0;
        mode = 2'd3;
        ph(1, 1, dcnt);
        ph(1, 0, dcnt);
        if (restart) begin
            ph(0, 1, dcnt); ph(1, 1, dcnt); ph(0, 0, dcnt); ph(1, 0, dcnt);
            ph(1, 1, dcnt); ph(1, 0, dcnt);
        end
        for (int i = 0; i < 8; i++) begin
            ph(0, b[i], dcnt);
            ph(1, b[i], dcnt);
        end
        ph(0, 0, dcnt);
        ph(1, 0, dcnt);
        chk(dcnt == 0, "R8 no done before stop", dcnt, 0);
        ph(1, 1, dcnt);
        chk(dcnt == 1, "R8 done on stop", dcnt, 1);
        chk(rx_data_o == b, "R8 received byte", rx_data_o, b);
        ph(1, 1, dcnt);
    endtask

    initial begin
        logic [7:0] pats [6];
        int sa, sc;
        pats = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80};
        repeat (3) @(negedge clk);
        chk(sck_o && !sck_oe_o && sdo_o && !sdo_oe_o && !done_o && rx_data_o == 0 &&
            !frame_err_o, "R1 reset state", {sck_o, sck_oe_o, sdo_o, sdo_oe_o}, 4'b1010);
        rst_n = 1'b1;
        @(negedge clk);

        for (int md = 0; md < 2; md++) begin
            for (int dv = 0; dv < 4; dv += (dv == 0 ? 1 : 2)) begin
                for (int p = 0; p < 6; p++) begin
                    run_master(md == 0 ? 2'd0 : 2'd2, dv, pats[p] ^ 8'(p * 37),
                               pats[5 - p] ^ 8'(dv * 11), 1'b0);
                end
            end
        end
        run_master(2'd0, 2, 8'h3C, 8'hC3, 1'b1);

        for (int dv = 0; dv < 2; dv++)
            for (int p = 0; p < 4; p++)
                run_async_tx(dv, pats[p + 2] ^ 8'(dv * 3));

        for (int dv = 0; dv < 2; dv++) begin
            for (int p = 0; p < 4; p++) begin
                logic [7:0] b = pats[p] ^ 8'(17 * p + dv);
                drive_async(dv, b, 1'b1, sa, sc);
                chk(sc == 1 && sa == 19 * 4 * (dv + 1) + 1, "R6 receive done timing",
                    sa, 19 * 4 * (dv + 1) + 1);
                chk(rx_data_o == b, "R6 received byte", rx_data_o, b);
                chk(!frame_err_o, "R7 good stop clears error", frame_err_o, 0);
            end
        end

        drive_async(1, 8'h6E, 1'b0, sa, sc);
        chk(sc == 1 && frame_err_o, "R7 framing error flagged", frame_err_o, 1);
        chk(rx_data_o == 8'h6E, "R7 data kept with error", rx_data_o, 8'h6E);
        drive_async(1, 8'h91, 1'b1, sa, sc);
        chk(!frame_err_o && rx_data_o == 8'h91, "R7 error cleared", frame_err_o, 0);

        // false start: short low glitch
        sdi_t = 1'b0;
        @(negedge clk);
        sdi_t = 1'b1;
        sc = 0;
        repeat (200) begin
            @(negedge clk);
            if (done_o) sc++;
        end
        chk(sc == 0 && rx_data_o == 8'h91, "R6 false start dropped", sc, 0);

        run_bus_slave(8'hB4, 1'b0);
        run_bus_slave(8'h2D, 1'b1);
        run_bus_slave(8'hFF, 1'b0);

        mode = 2'd3; tx_data = 8'h55; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        sc = 0;
        repeat (40) begin
            @(negedge clk);
            if (sck_oe_o || sdo_oe_o || done_o) sc++;
        end
        chk(sc == 0, "R9 start ignored in mode 3", sc, 0);

        finish_run();
    end
endmodule